// File: doc/BRIEF.md
# Single-Channel DMA Control and Status Registers

This block is the register front end of a single DMA channel. A host reaches three 32-bit registers over a simple write strobe and a combinational read port. The registers are control/status at byte offset 0x00, the address at 0x04 and the byte count at 0x08. The channel keeps two address/count pairs: a current pair and a next pair. Software stages the byte count first and then writes the address. That address write commits the pair into the next slot. When the current pair is empty or has run out, the next pair moves into the current slot.

While enabled, the channel walks the current pair with burst requests on an abstract memory port. Each request carries an address, a direction and a beat count of 32-bit words. It stays up until the memory acknowledges it. The channel keeps completion, error and device-event status, which software clears by writing a 1 to the pending bits. A single interrupt line reports that status. A software reset lets any request in flight finish and then returns the channel to idle.

Top module: `dma_chan_regs`

## Requirements
- R1: After rst_ni is released, control/status reads DEV_ID in bits 31:28 and zero elsewhere, the address and count registers read 0, and mem_req_o and irq_o are low.
- R2: The control bits read back as written: interrupt enable (bit 4), direction (bit 8), DMA enable (bit 9), count enable (bit 13), burst code (bits 19:18), completion-interrupt mask (bit 23) and enable-next (bit 24).
- R3: An address write with DMA enable set and no next pair held commits {that address, last written count} and sets bit 27. One cycle later, if no current pair is held, the pair becomes current: bit 26 and bit 25 (channel on) read 1, bit 27 reads 0, and the address and count registers show the pair.
- R4: An address write is ignored while bit 27 is set or bit 9 is clear. The held next pair is unchanged, and no transfer is started from the ignored write.
- R5: Burst code 00 allows 4 words, 01 allows 8, 11 allows 16 and 10 allows 1. Each request shows the current address, mem_wr_o equal to bit 8, and mem_beats_o equal to min(allowed words, ceil(residue/4)).
- R6: On an acknowledge without an error, the address advances by 4 times the beat count. With bit 13 set, the residue drops by min(residue, 4 times the beat count). With bit 13 clear, the residue holds.
- R7: A request stays asserted with a stable address and beat count until it is acknowledged.
- R8: When a held current pair reaches a zero residue with no request outstanding, bit 14 (terminal count) and bit 0 (interrupt pending) are set. In that same cycle a held next pair becomes current. Otherwise bit 26 clears.
- R9: Writing a 1 to bit 0, 1 or 14 clears that bit, so writing back the value just read clears every pending bit that was read as set.
- R10: irq_o is high when bit 4 is set and either bit 1 is set or bit 0 is set, except when bit 0 stems from terminal count (bit 14) and bit 23 is set. A one-cycle dev_evt_i pulse sets bit 0 without setting bit 14.
- R11: An acknowledge with mem_err_i high sets bit 1 and leaves the address and residue unchanged. No further request starts until bit 1 is cleared.
- R12: Writing 1 to bit 7 starts a reset. While the reset is pending, bit 7 and bit 2 (draining) read 1, and bit 10 mirrors an outstanding request. An outstanding request is held until acknowledged. Once none is outstanding, all pending, loaded and control bits return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Byte address bits 3:2 selecting the register |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |
| mem_req_o | output | 1 | Burst request |
| mem_addr_o | output | ADDR_W | Burst start address |
| mem_wr_o | output | 1 | Burst direction, 1 = write to memory |
| mem_beats_o | output | 5 | Words in the burst |
| mem_ack_i | input | 1 | Burst acknowledge |
| mem_err_i | input | 1 | Error flag qualified by mem_ack_i |
| dev_evt_i | input | 1 | Device event pulse |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench runs seeded random transfers that mix burst codes, odd byte counts and random acknowledge delays. For each of these it predicts every burst, so a design that rounds the short final burst wrongly or decodes the burst code linearly shows a wrong beat count or a wrong final address. Directed cases cover several failure modes:
- A second address write while a next pair is held: a design that overwrites the held pair runs the wrong buffer.
- A reset with a request outstanding: a design that drops the request or clears state early breaks the handshake.
- An errored acknowledge: a design that advances the address or keeps requesting is caught.
- A device event and a completion with the completion interrupt masked: a gate wired the wrong way raises or hides irq_o.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int CSR_INT  = 0;
  localparam int CSR_ERR  = 1;
  localparam int CSR_DRN  = 2;
  localparam int CSR_IEN  = 4;
  localparam int CSR_RST  = 7;
  localparam int CSR_DIR  = 8;
  localparam int CSR_EN   = 9;
  localparam int CSR_CYC  = 10;
  localparam int CSR_CEN  = 13;
  localparam int CSR_TC   = 14;
  localparam int CSR_BLO  = 18;
  localparam int CSR_TCID = 23;
  localparam int CSR_ENX  = 24;
  localparam int CSR_ON   = 25;
  localparam int CSR_AL   = 26;
  localparam int CSR_NAL  = 27;

  localparam int MAX_BEATS = 16;
  localparam int BEAT_W    = $clog2(MAX_BEATS + 1);

  localparam logic [1:0] SEL_CSR = 2'd0;
  localparam logic [1:0] SEL_ADR = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;

  typedef enum logic [1:0] {
    BSZ_4  = 2'b00,
    BSZ_8  = 2'b01,
    BSZ_1  = 2'b10,
    BSZ_16 = 2'b11
  } bsize_e;

  function automatic logic [BEAT_W-1:0] burst_words(input logic [1:0] code);
    case (bsize_e'(code))
      BSZ_4:   return BEAT_W'(4);
      BSZ_8:   return BEAT_W'(8);
      BSZ_1:   return BEAT_W'(1);
      default: return BEAT_W'(MAX_BEATS);
    endcase
  endfunction
endpackage

// File: rtl/dma_burst_eng.sv
module dma_burst_eng
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        bsize_i,
  input  logic              mack_i,
  output logic              req_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic              done_o
);
  localparam int WRD_W = CNT_W - 1;

  logic              busy_q;
  logic [BEAT_W-1:0] beats_q, cap, beats_nxt;
  logic [WRD_W-1:0]  words;

  // words left, rounded up
  assign words     = WRD_W'(cnt_i[CNT_W-1:2]) + WRD_W'(|cnt_i[1:0]);
  assign cap       = burst_words(bsize_i);
  assign beats_nxt = (words < WRD_W'(cap)) ? words[BEAT_W-1:0] : cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      beats_q <= '0;
    end else if (busy_q) begin
      if (mack_i) busy_q <= 1'b0;
    end else if (go_i) begin
      busy_q  <= 1'b1;
      beats_q <= beats_nxt;
    end
  end

  assign req_o   = busy_q;
  assign beats_o = beats_q;
  assign done_o  = busy_q & mack_i;

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !mack_i |=> busy_q && $stable(beats_q));
  assert_beats_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (beats_q != '0) && (beats_q <= BEAT_W'(MAX_BEATS)));
endmodule

// File: rtl/dma_pair_slots.sv
module dma_pair_slots
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_we_i,
  input  logic              addr_we_i,
  input  logic [31:0]       wdata_i,
  input  logic              en_cnt_i,
  input  logic              done_i,
  input  logic              err_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic              busy_i,
  input  logic              clr_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0]  cur_cnt_o,
  output logic              a_ld_o,
  output logic              na_ld_o,
  output logic              finish_o
);
  logic [ADDR_W-1:0] cur_addr_q, nxt_addr_q;
  logic [CNT_W-1:0]  cur_cnt_q, nxt_cnt_q, stage_q, step_b, dec;
  logic              a_ld_q, na_ld_q, finish, promote;

  assign finish  = a_ld_q && (cur_cnt_q == '0) && !busy_i;
  assign promote = na_ld_q && (!a_ld_q || finish);
  assign step_b  = CNT_W'({beats_i, 2'b00});
  assign dec     = (cur_cnt_q < step_b) ? cur_cnt_q : step_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_addr_q <= '0; nxt_addr_q <= '0;
      cur_cnt_q  <= '0; nxt_cnt_q  <= '0; stage_q <= '0;
      a_ld_q     <= 1'b0; na_ld_q  <= 1'b0;
    end else if (clr_i) begin
      a_ld_q  <= 1'b0;
      na_ld_q <= 1'b0;
    end else begin
      if (cnt_we_i) stage_q <= wdata_i[CNT_W-1:0];
      if (addr_we_i) begin
        nxt_addr_q <= wdata_i[ADDR_W-1:0];
        nxt_cnt_q  <= stage_q;
        na_ld_q    <= 1'b1;
      end
      if (done_i && !err_i) begin
        cur_addr_q <= cur_addr_q + ADDR_W'({beats_i, 2'b00});
        if (en_cnt_i) cur_cnt_q <= cur_cnt_q - dec;
      end
      if (promote) begin
        cur_addr_q <= nxt_addr_q;
        cur_cnt_q  <= nxt_cnt_q;
        a_ld_q     <= 1'b1;
        na_ld_q    <= 1'b0;
      end else if (finish) begin
        a_ld_q <= 1'b0;
      end
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;
  assign a_ld_o     = a_ld_q;
  assign na_ld_o    = na_ld_q;
  assign finish_o   = finish;

  assert_next_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    na_ld_q |=> !na_ld_q || ($stable(nxt_addr_q) && $stable(nxt_cnt_q)));
  assert_residue_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_ld_q && !promote |=> cur_cnt_q <= $past(cur_cnt_q));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int         ADDR_W = 32,
  parameter int         CNT_W  = 24,
  parameter logic [3:0] DEV_ID = 4'h5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [3:2]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_wr_o,
  output logic [BEAT_W-1:0] mem_beats_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic              dev_evt_i,
  output logic              irq_o
);
  logic int_pend, err_pend, tc, int_en, dir, en_dma, en_cnt, tci_dis, en_next, rst_req;
  logic [1:0] bsize;
  logic csr_we, cnt_we, addr_acc, go, busy, done, finish, soft_done, a_ld, na_ld;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt;
  logic [BEAT_W-1:0] beats;
  logic [31:0]       csr_rd;

  assign csr_we    = reg_wr_i && (reg_addr_i == SEL_CSR);
  assign cnt_we    = reg_wr_i && (reg_addr_i == SEL_CNT);
  assign addr_acc  = reg_wr_i && (reg_addr_i == SEL_ADR) && en_dma && !na_ld && !rst_req;
  assign go        = en_dma && a_ld && (cur_cnt != '0) && !rst_req && !err_pend;
  assign soft_done = rst_req && !busy;

  dma_burst_eng #(.CNT_W(CNT_W)) u_eng (
    .clk_i, .rst_ni, .go_i(go), .cnt_i(cur_cnt), .bsize_i(bsize),
    .mack_i(mem_ack_i), .req_o(busy), .beats_o(beats), .done_o(done)
  );

  dma_pair_slots #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slots (
    .clk_i, .rst_ni, .cnt_we_i(cnt_we), .addr_we_i(addr_acc), .wdata_i(reg_wdata_i),
    .en_cnt_i(en_cnt), .done_i(done), .err_i(mem_err_i), .beats_i(beats),
    .busy_i(busy), .clr_i(soft_done), .cur_addr_o(cur_addr), .cur_cnt_o(cur_cnt),
    .a_ld_o(a_ld), .na_ld_o(na_ld), .finish_o(finish)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || soft_done) begin
      {int_pend, err_pend, tc, int_en, dir, en_dma, en_cnt, tci_dis, en_next, rst_req} <= '0;
      bsize <= '0;
    end else begin
      if (csr_we) begin
        int_en  <= reg_wdata_i[CSR_IEN];
        dir     <= reg_wdata_i[CSR_DIR];
        en_dma  <= reg_wdata_i[CSR_EN];
        en_cnt  <= reg_wdata_i[CSR_CEN];
        bsize   <= reg_wdata_i[CSR_BLO+1:CSR_BLO];
        tci_dis <= reg_wdata_i[CSR_TCID];
        en_next <= reg_wdata_i[CSR_ENX];
        if (reg_wdata_i[CSR_RST]) rst_req <= 1'b1;
      end
      // hardware set wins over a same-cycle clear
      int_pend <= (int_pend && !(csr_we && reg_wdata_i[CSR_INT])) || finish || dev_evt_i;
      err_pend <= (err_pend && !(csr_we && reg_wdata_i[CSR_ERR])) || (done && mem_err_i);
      tc       <= (tc && !(csr_we && reg_wdata_i[CSR_TC])) || finish;
    end
  end

  always_comb begin
    csr_rd                       = '0;
    csr_rd[CSR_INT]              = int_pend;
    csr_rd[CSR_ERR]              = err_pend;
    csr_rd[CSR_DRN]              = rst_req;
    csr_rd[CSR_IEN]              = int_en;
    csr_rd[CSR_RST]              = rst_req;
    csr_rd[CSR_DIR]              = dir;
    csr_rd[CSR_EN]               = en_dma;
    csr_rd[CSR_CYC]              = busy;
    csr_rd[CSR_CEN]              = en_cnt;
    csr_rd[CSR_TC]               = tc;
    csr_rd[CSR_BLO+1:CSR_BLO]    = bsize;
    csr_rd[CSR_TCID]             = tci_dis;
    csr_rd[CSR_ENX]              = en_next;
    csr_rd[CSR_ON]               = en_dma && a_ld;
    csr_rd[CSR_AL]               = a_ld;
    csr_rd[CSR_NAL]              = na_ld;
    csr_rd[31:28]                = DEV_ID;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      SEL_CSR: reg_rdata_o = csr_rd;
      SEL_ADR: reg_rdata_o[ADDR_W-1:0] = cur_addr;
      SEL_CNT: reg_rdata_o[CNT_W-1:0]  = cur_cnt;
      default: reg_rdata_o = '0;
    endcase
  end

  assign mem_req_o   = busy;
  assign mem_addr_o  = cur_addr;
  assign mem_wr_o    = dir;
  assign mem_beats_o = beats;
  assign irq_o       = int_en && (err_pend || (int_pend && !(tc && tci_dis)));

  assert_reset_waits_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req && busy |=> rst_req && busy == !$past(mem_ack_i));
  assert_reset_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_done |=> !en_dma && !int_en && !a_ld && !na_ld && !rst_req);
  assert_err_halts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pend && !busy |=> !busy);
  assert_evt_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_evt_i && !soft_done |=> int_pend);
  assert_addr_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !mem_ack_i |=> $stable(mem_addr_o));
endmodule

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;
  localparam logic [31:0] ID_BITS = 32'h5000_0000;
  localparam int B_INT = 0, B_ERR = 1, B_DRN = 2, B_IEN = 4, B_RST = 7, B_DIR = 8, B_EN = 9,
                 B_CYC = 10, B_CEN = 13, B_TC = 14, B_BSZ = 18, B_TCID = 23, B_ENX = 24,
                 B_ON = 25, B_AL = 26, B_NAL = 27;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, mack = 1'b0, merr = 1'b0, devevt = 1'b0;
  logic [3:2] addr = 2'd0;
  logic [31:0] wdata = '0, rdata, maddr;
  logic req, mwr, irq;
  logic [4:0] mbeats;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mem_req_o(req), .mem_addr_o(maddr), .mem_wr_o(mwr),
    .mem_beats_o(mbeats), .mem_ack_i(mack), .mem_err_i(merr), .dev_evt_i(devevt), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic int bwords(input logic [1:0] code);
    case (code)
      2'b00: return 4;
      2'b01: return 8;
      2'b10: return 1;
      default: return 16;
    endcase
  endfunction

  function automatic int exp_beats(input int unsigned rem, input int bw);
    int unsigned w = (rem + 3) / 4;
    return (w < bw) ? w : bw;
  endfunction

  task automatic wait_req();
    for (int w = 0; w < 50 && !req; w++) @(negedge clk);
  endtask

  task automatic serve(inout int unsigned ea, inout int unsigned rem, input int bw,
                       input bit dir);
    int nb, d;
    wait_req();
    chk("R5 request present", req, 1);
    nb = exp_beats(rem, bw);
    chk("R5 beats", mbeats, nb);
    chk("R5 address", maddr, ea);
    chk("R5 direction", mwr, dir);
    d = $urandom % 4;
    for (int k = 0; k < d; k++) begin
      @(negedge clk);
      chk("R7 request held", req, 1);
      chk("R7 beats stable", mbeats, nb);
      chk("R7 address stable", maddr, ea);
    end
    mack = 1'b1; @(negedge clk); mack = 1'b0;
    ea  += 4 * nb;
    rem -= (rem < 4 * nb) ? rem : 4 * nb;
  endtask

  task automatic clear_pending();
    logic [31:0] v;
    rd_reg(2'd0, v);
    wr_reg(2'd0, v);
    rd_reg(2'd0, v);
    chk("R9 pending cleared", v & 32'h0000_4003, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned ea, rem, a0, c0;
    logic [1:0] code;
    bit dir;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(2'd0, v); chk("R1 csr", v, ID_BITS);
    rd_reg(2'd1, v); chk("R1 addr", v, 0);
    rd_reg(2'd2, v); chk("R1 count", v, 0);
    chk("R1 irq", irq, 0); chk("R1 req", req, 0);

    // R2 control readback
    v = (1 << B_IEN) | (1 << B_DIR) | (1 << B_CEN) | (3 << B_BSZ) | (1 << B_TCID) | (1 << B_ENX);
    wr_reg(2'd0, v);
    rd_reg(2'd0, wdata); chk("R2 readback", wdata, v | ID_BITS);
    wr_reg(2'd0, 0);
    rd_reg(2'd0, v); chk("R2 cleared", v, ID_BITS);

    // R4 address write ignored with DMA disabled
    wr_reg(2'd2, 16); wr_reg(2'd1, 32'h100);
    repeat (2) @(negedge clk);
    rd_reg(2'd0, v); chk("R4 no pair when disabled", v, ID_BITS);
    chk("R4 no request", req, 0);

    // random transfers: R3 R5 R6 R8 R9
    for (int i = 0; i < 16; i++) begin
      code = 2'($urandom % 4);
      dir  = 1'($urandom % 2);
      c0   = 1 + $urandom % 120;
      a0   = $urandom & 32'h00FF_FFFC;
      wr_reg(2'd0, (1 << B_EN) | (1 << B_CEN) | (1 << B_IEN) | (32'(dir) << B_DIR) | (32'(code) << B_BSZ));
      wr_reg(2'd2, c0);
      wr_reg(2'd1, a0);
      if (i == 0) begin
        rd_reg(2'd0, v);
        chk("R3 next loaded", v[B_NAL], 1); chk("R3 current empty", v[B_AL], 0);
        @(negedge clk);
        rd_reg(2'd0, v);
        chk("R3 current loaded", v[B_AL], 1); chk("R3 next free", v[B_NAL], 0);
        chk("R3 channel on", v[B_ON], 1);
        rd_reg(2'd1, v); chk("R3 addr reg", v, a0);
        rd_reg(2'd2, v); chk("R3 count reg", v, c0);
      end
      ea = a0; rem = c0;
      while (rem > 0) serve(ea, rem, bwords(code), dir);
      repeat (2) @(negedge clk);
      rd_reg(2'd0, v);
      chk("R8 terminal count", v[B_TC], 1); chk("R8 int pending", v[B_INT], 1);
      chk("R8 current released", v[B_AL], 0);
      chk("R10 irq on completion", irq, 1);
      rd_reg(2'd1, v); chk("R6 final addr", v, ea);
      rd_reg(2'd2, v); chk("R6 final residue", v, 0);
      clear_pending();
      chk("R9 irq dropped", irq, 0);
    end

    // R8 R4 double buffering, one-word bursts
    wr_reg(2'd0, (1 << B_EN) | (1 << B_CEN) | (1 << B_ENX) | (2 << B_BSZ));
    wr_reg(2'd2, 8);  wr_reg(2'd1, 32'h1000);
    wr_reg(2'd2, 12); wr_reg(2'd1, 32'h2000);
    rd_reg(2'd0, v); chk("R3 second pair held", v[B_NAL], 1);
    wr_reg(2'd2, 40); wr_reg(2'd1, 32'h3000);
    ea = 32'h1000; rem = 8;
    while (rem > 0) serve(ea, rem, 1, 0);
    ea = 32'h2000; rem = 12;
    while (rem > 0) serve(ea, rem, 1, 0);
    repeat (10) @(negedge clk);
    chk("R4 ignored pair never runs", req, 0);
    rd_reg(2'd1, v); chk("R4 addr after held pair", v, 32'h200C);
    rd_reg(2'd0, v); chk("R8 done after chain", v[B_AL], 0);
    clear_pending();

    // R11 error acknowledge
    wr_reg(2'd0, (1 << B_EN) | (1 << B_CEN) | (1 << B_IEN) | (2 << B_BSZ));
    wr_reg(2'd2, 8); wr_reg(2'd1, 32'h400);
    wait_req();
    merr = 1'b1; mack = 1'b1; @(negedge clk); merr = 1'b0; mack = 1'b0;
    rd_reg(2'd0, v); chk("R11 error pending", v[B_ERR], 1);
    chk("R10 irq on error", irq, 1);
    rd_reg(2'd1, v); chk("R11 addr held", v, 32'h400);
    rd_reg(2'd2, v); chk("R11 count held", v, 8);
    repeat (5) @(negedge clk);
    chk("R11 no request while error", req, 0);
    clear_pending();
    ea = 32'h400; rem = 8;
    while (rem > 0) serve(ea, rem, 1, 0);
    repeat (2) @(negedge clk);
    clear_pending();

    // R6 count hold and R12 reset with request outstanding
    wr_reg(2'd0, (1 << B_EN) | (2 << B_BSZ));
    wr_reg(2'd2, 8); wr_reg(2'd1, 32'h800);
    wait_req();
    mack = 1'b1; @(negedge clk); mack = 1'b0;
    wait_req();
    chk("R6 addr advances", maddr, 32'h804);
    rd_reg(2'd2, v); chk("R6 count held", v, 8);
    wr_reg(2'd0, 1 << B_RST);
    rd_reg(2'd0, v);
    chk("R12 reset reads 1", v[B_RST], 1); chk("R12 draining", v[B_DRN], 1);
    chk("R12 cycle pending", v[B_CYC], 1);
    repeat (3) @(negedge clk);
    chk("R12 request held", req, 1);
    mack = 1'b1; @(negedge clk); mack = 1'b0;
    repeat (2) @(negedge clk);
    rd_reg(2'd0, v); chk("R12 idle after reset", v, ID_BITS);
    chk("R12 no request", req, 0);

    // R10 device event and masked completion
    wr_reg(2'd0, (1 << B_IEN) | (1 << B_TCID));
    @(negedge clk); devevt = 1'b1; @(negedge clk); devevt = 1'b0;
    rd_reg(2'd0, v);
    chk("R10 event pending", v[B_INT], 1); chk("R10 no terminal count", v[B_TC], 0);
    chk("R10 event irq", irq, 1);
    clear_pending();
    wr_reg(2'd0, (1 << B_EN) | (1 << B_CEN) | (1 << B_IEN) | (1 << B_TCID));
    wr_reg(2'd2, 4); wr_reg(2'd1, 32'h40);
    ea = 32'h40; rem = 4;
    serve(ea, rem, 4, 0);
    repeat (2) @(negedge clk);
    rd_reg(2'd0, v);
    chk("R10 masked completion tc", v[B_TC], 1);
    chk("R10 masked completion irq", irq, 0);
    clear_pending();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule